// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block keeps a bank of pending interrupt sources grouped into priority levels. Each level owns a word of individually addressable source bits. Requesters post or clear one source per cycle (level, index), or wipe the whole bank at once. A status vector carries one bit per level, and that bit stays high for as long as any source of the level is still pending.

The block scans for the highest requesting level on every cycle. It works from a narrow software request vector and from the status bits of the external levels. A software request bit j maps to level j+1. The external levels map one to one onto their own numbers and always outrank software. The scan also builds a mask with one bit for each contributing level. When the winning level is non-zero, above the current priority threshold, and the program counter is aligned to an instruction, the block signals a take on the next clock edge. In the same edge it latches the level and the mask into output registers, which the exception logic then reads.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A valid post with level < NUM_LEVELS and index < SRC_PER_LEVEL sets that source bit on the next edge, and statusSummary[level] reads 1 from the next cycle on.
- R2: A valid in-range clear drops that source bit. statusSummary[level] falls only when no other source of that level remains pending.
- R3: clearAll empties every level and zeroes statusSummary on the next edge. It overrides any post or clear issued in the same cycle.
- R4: When a post and a clear address the same source in the same cycle, the source ends up pending.
- R5: intPending is high exactly when statusSummary is non-zero and pcAlign is 2'b00. It is combinational on the present state.
- R6: The candidate level is found in two steps. First it is the highest software level: swRequest bit j stands for level j+1 and sets mask bit SW_MIN+j. Then any pending external level e in [EXT_MIN, EXT_MAX) replaces it, so the highest pending external level wins, and each such level sets mask bit e.
- R7: takeValid is high in the cycle after an edge at which the candidate level was non-zero, strictly greater than threshold, and pcAlign was 2'b00. It is low otherwise.
- R8: On a take, isrOut receives the mask and intIdOut the level. Without a take, both hold their values.
- R9: A valid post or clear whose level ≥ NUM_LEVELS or index ≥ SRC_PER_LEVEL changes no state, and it raises reqError for exactly the following cycle.
- R10: A synchronous active-high rst empties all levels and zeroes statusSummary, isrOut, intIdOut, takeValid and reqError.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| postValid | input | 1 | Post request strobe |
| postLevel | input | LVL_W+1 | Level to post (extra bit allows out-of-range values) |
| postIndex | input | IDX_W+1 | Source index to post |
| clearValid | input | 1 | Clear request strobe |
| clearLevel | input | LVL_W+1 | Level to clear |
| clearIndex | input | IDX_W+1 | Source index to clear |
| clearAll | input | 1 | Empty every level |
| swRequest | input | SW_MAX-SW_MIN | Software requests, bit j = level j+1 |
| threshold | input | LVL_W | Current priority threshold |
| pcAlign | input | 2 | Two low bits of the program counter |
| intPending | output | 1 | Some level pending and PC aligned |
| statusSummary | output | NUM_LEVELS | Per-level non-empty flags |
| takeValid | output | 1 | Interrupt taken at the last edge |
| isrOut | output | NUM_LEVELS | Latched summary mask |
| intIdOut | output | LVL_W | Latched interrupt level |
| reqError | output | 1 | Out-of-range request seen at the last edge |

## Verification
The bound checker checks on every cycle the rules that follow from one edge. An in-range post with no clearAll leaves its status bit set, clearAll leaves the status empty, and an out-of-range request raises the error pulse. A take always carries a non-zero level above the previous threshold. The output registers stay still without a take, and intPending stays low while the PC is misaligned. Other behaviour depends on the contents of a whole level, so only the bench scenarios can show it. This covers a status bit that survives a clear while a sibling source remains, the exact priority merge between software and external levels, and the mask contents. The bench compares all of these against a bit-level model of every pending word.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  // Strobes issued by the control half to the datapath each cycle.
  typedef struct packed {
    logic postOk;    // validated post
    logic clearOk;   // validated clear
    logic wipe;      // empty every level
    logic take;      // latch level and mask into output registers
  } irqStrobes_t;
endpackage

// File: rtl/lvl_irq_datapath.sv
module lvl_irq_datapath
  import lvl_irq_pkg::*;
#(
  parameter int NUM_LEVELS    = 32,
  parameter int SRC_PER_LEVEL = 64,
  parameter int SW_MIN        = 1,
  parameter int SW_MAX        = 16,
  parameter int EXT_MIN       = 16,
  parameter int EXT_MAX       = 32,
  localparam int LVL_W        = $clog2(NUM_LEVELS),
  localparam int IDX_W        = $clog2(SRC_PER_LEVEL),
  localparam int SW_COUNT     = SW_MAX - SW_MIN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  irqStrobes_t           strb,
  input  logic [LVL_W-1:0]      postLevel,
  input  logic [IDX_W-1:0]      postIndex,
  input  logic [LVL_W-1:0]      clearLevel,
  input  logic [IDX_W-1:0]      clearIndex,
  input  logic [SW_COUNT-1:0]   swRequest,
  output logic [NUM_LEVELS-1:0] statusSummary,
  output logic [LVL_W-1:0]      candLevel,
  output logic [NUM_LEVELS-1:0] isrOut,
  output logic [LVL_W-1:0]      intIdOut
);
  localparam logic [SRC_PER_LEVEL-1:0] ONE_SRC = SRC_PER_LEVEL'(1);

  logic [SRC_PER_LEVEL-1:0] postBit, clearBit;
  logic [NUM_LEVELS-1:0]    candMask;
  logic [NUM_LEVELS-1:0]    statusReg;

  assign postBit  = ONE_SRC << postIndex;
  assign clearBit = ONE_SRC << clearIndex;

  // One pending word and one status bit per level.
  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
    localparam logic [LVL_W-1:0] THIS_LVL = LVL_W'(l);
    logic [SRC_PER_LEVEL-1:0] pendWord, pendNext, setMask, dropMask;

    assign setMask  = (strb.postOk  && postLevel  == THIS_LVL) ? postBit  : '0;
    assign dropMask = (strb.clearOk && clearLevel == THIS_LVL) ? clearBit : '0;
    // Post is applied after the clear so it wins on a shared bit.
    assign pendNext = strb.wipe ? '0 : ((pendWord & ~dropMask) | setMask);

    always_ff @(posedge clk) begin
      if (rst) begin
        pendWord     <= '0;
        statusReg[l] <= 1'b0;
      end else begin
        pendWord     <= pendNext;
        statusReg[l] <= |pendNext;
      end
    end
  end

  assign statusSummary = statusReg;

  // Software bits first, external levels after; later hits override.
  always_comb begin
    candLevel = '0;
    candMask  = '0;
    for (int j = 0; j < SW_COUNT; j++) begin
      if (swRequest[j]) begin
        candLevel           = LVL_W'(j + 1);
        candMask[SW_MIN + j] = 1'b1;
      end
    end
    for (int e = EXT_MIN; e < EXT_MAX; e++) begin
      if (statusReg[e]) begin
        candLevel   = LVL_W'(e);
        candMask[e] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isrOut   <= '0;
      intIdOut <= '0;
    end else if (strb.take) begin
      isrOut   <= candMask;
      intIdOut <= candLevel;
    end
  end
endmodule

// File: rtl/lvl_irq_control.sv
module lvl_irq_control
  import lvl_irq_pkg::*;
#(
  parameter int NUM_LEVELS    = 32,
  parameter int SRC_PER_LEVEL = 64,
  localparam int LVL_W        = $clog2(NUM_LEVELS),
  localparam int IDX_W        = $clog2(SRC_PER_LEVEL),
  localparam int LVL_IN_W     = LVL_W + 1,
  localparam int IDX_IN_W     = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  postValid,
  input  logic [LVL_IN_W-1:0]   postLevel,
  input  logic [IDX_IN_W-1:0]   postIndex,
  input  logic                  clearValid,
  input  logic [LVL_IN_W-1:0]   clearLevel,
  input  logic [IDX_IN_W-1:0]   clearIndex,
  input  logic                  clearAll,
  input  logic [LVL_W-1:0]      threshold,
  input  logic [1:0]            pcAlign,
  input  logic [LVL_W-1:0]      candLevel,
  input  logic [NUM_LEVELS-1:0] statusSummary,
  output irqStrobes_t           strb,
  output logic                  intPending,
  output logic                  takeValid,
  output logic                  reqError
);
  localparam logic [LVL_IN_W-1:0] LVL_LIMIT = LVL_IN_W'(NUM_LEVELS);
  localparam logic [IDX_IN_W-1:0] IDX_LIMIT = IDX_IN_W'(SRC_PER_LEVEL);

  logic postInRange, clearInRange, pcAligned, badReq;

  assign postInRange  = (postLevel  < LVL_LIMIT) && (postIndex  < IDX_LIMIT);
  assign clearInRange = (clearLevel < LVL_LIMIT) && (clearIndex < IDX_LIMIT);
  assign pcAligned    = (pcAlign == 2'b00);
  assign badReq       = (postValid && !postInRange) || (clearValid && !clearInRange);

  always_comb begin
    strb.postOk  = postValid  && postInRange;
    strb.clearOk = clearValid && clearInRange;
    strb.wipe    = clearAll;
    strb.take    = (candLevel != '0) && (candLevel > threshold) && pcAligned;
  end

  assign intPending = (statusSummary != '0) && pcAligned;

  always_ff @(posedge clk) begin
    if (rst) begin
      takeValid <= 1'b0;
      reqError  <= 1'b0;
    end else begin
      takeValid <= strb.take;
      reqError  <= badReq;
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_LEVELS    = 32,
  parameter int SRC_PER_LEVEL = 64,
  parameter int SW_MIN        = 1,
  parameter int SW_MAX        = 16,
  parameter int EXT_MIN       = 16,
  parameter int EXT_MAX       = 32,
  localparam int LVL_W        = $clog2(NUM_LEVELS),
  localparam int IDX_W        = $clog2(SRC_PER_LEVEL),
  localparam int SW_COUNT     = SW_MAX - SW_MIN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  postValid,
  input  logic [LVL_W:0]        postLevel,
  input  logic [IDX_W:0]        postIndex,
  input  logic                  clearValid,
  input  logic [LVL_W:0]        clearLevel,
  input  logic [IDX_W:0]        clearIndex,
  input  logic                  clearAll,
  input  logic [SW_COUNT-1:0]   swRequest,
  input  logic [LVL_W-1:0]      threshold,
  input  logic [1:0]            pcAlign,
  output logic                  intPending,
  output logic [NUM_LEVELS-1:0] statusSummary,
  output logic                  takeValid,
  output logic [NUM_LEVELS-1:0] isrOut,
  output logic [LVL_W-1:0]      intIdOut,
  output logic                  reqError
);
  irqStrobes_t      strb;
  logic [LVL_W-1:0] candLevel;

  lvl_irq_control #(
    .NUM_LEVELS(NUM_LEVELS), .SRC_PER_LEVEL(SRC_PER_LEVEL)
  ) u_control (
    .clk, .rst, .postValid, .postLevel, .postIndex,
    .clearValid, .clearLevel, .clearIndex, .clearAll,
    .threshold, .pcAlign, .candLevel, .statusSummary,
    .strb, .intPending, .takeValid, .reqError
  );

  lvl_irq_datapath #(
    .NUM_LEVELS(NUM_LEVELS), .SRC_PER_LEVEL(SRC_PER_LEVEL),
    .SW_MIN(SW_MIN), .SW_MAX(SW_MAX), .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX)
  ) u_datapath (
    .clk, .rst, .strb,
    .postLevel(postLevel[LVL_W-1:0]), .postIndex(postIndex[IDX_W-1:0]),
    .clearLevel(clearLevel[LVL_W-1:0]), .clearIndex(clearIndex[IDX_W-1:0]),
    .swRequest, .statusSummary, .candLevel, .isrOut, .intIdOut
  );
endmodule

// File: rtl/lvl_irq_checker.sv
module lvl_irq_checker #(
  parameter int NUM_LEVELS    = 32,
  parameter int SRC_PER_LEVEL = 64,
  localparam int LVL_W        = $clog2(NUM_LEVELS),
  localparam int IDX_W        = $clog2(SRC_PER_LEVEL)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  postValid,
  input logic [LVL_W:0]        postLevel,
  input logic [IDX_W:0]        postIndex,
  input logic                  clearAll,
  input logic [LVL_W-1:0]      threshold,
  input logic [1:0]            pcAlign,
  input logic                  intPending,
  input logic [NUM_LEVELS-1:0] statusSummary,
  input logic                  takeValid,
  input logic [NUM_LEVELS-1:0] isrOut,
  input logic [LVL_W-1:0]      intIdOut,
  input logic                  reqError
);
  logic postGood, postBad;
  assign postGood = postValid && (int'(postLevel) < NUM_LEVELS) && (int'(postIndex) < SRC_PER_LEVEL);
  assign postBad  = postValid && !postGood;

  // R1 and R4: an in-range post without clearAll always leaves its level flagged
  a_r1_post_sets: assert property (@(posedge clk) disable iff (rst)
    (postGood && !clearAll) |=> statusSummary[$past(postLevel[LVL_W-1:0])]);

  a_r3_clear_all: assert property (@(posedge clk) disable iff (rst)
    clearAll |=> (statusSummary == '0));

  a_r5_misaligned: assert property (@(posedge clk) disable iff (rst)
    (pcAlign != 2'b00) |-> !intPending);

  a_r7_take_above: assert property (@(posedge clk) disable iff (rst)
    takeValid |-> (intIdOut != '0) && (intIdOut > $past(threshold)) && ($past(pcAlign) == 2'b00));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !takeValid |-> ($stable(isrOut) && $stable(intIdOut)));

  a_r9_error_pulse: assert property (@(posedge clk) disable iff (rst)
    postBad |=> reqError);
endmodule

bind lvl_irq_ctrl lvl_irq_checker #(
  .NUM_LEVELS(NUM_LEVELS), .SRC_PER_LEVEL(SRC_PER_LEVEL)
) u_checker (
  .clk, .rst, .postValid, .postLevel, .postIndex, .clearAll,
  .threshold, .pcAlign, .intPending, .statusSummary,
  .takeValid, .isrOut, .intIdOut, .reqError
);

// File: tb/lvl_irq_ctrl_tb.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_tb;
  localparam int NL = 32, NS = 64, SWMIN = 1, SWMAX = 16, EXMIN = 16, EXMAX = 32;
  localparam int SWC = SWMAX - SWMIN;

  logic clk = 0, rst = 1;
  logic postValid = 0, clearValid = 0, clearAll = 0;
  logic [5:0] postLevel = 0, clearLevel = 0;
  logic [6:0] postIndex = 0, clearIndex = 0;
  logic [SWC-1:0] swRequest = 0;
  logic [4:0] threshold = 0;
  logic [1:0] pcAlign = 0;
  logic intPending, takeValid, reqError;
  logic [NL-1:0] statusSummary, isrOut;
  logic [4:0] intIdOut;

  always #10 clk = ~clk;

  lvl_irq_ctrl u_dut (.*);

  int nRun = 0, nFail = 0;
  logic [NS-1:0] mWord [NL];
  logic [NL-1:0] mIsr, eIsr;
  logic [4:0] mId, eId;
  logic eTake, eErr;

  function automatic logic [NL-1:0] mStatus();
    logic [NL-1:0] s;
    for (int l = 0; l < NL; l++) s[l] = |mWord[l];
    return s;
  endfunction

  function automatic logic [4:0] expLevel(logic [SWC-1:0] sw, logic [NL-1:0] st);
    logic [4:0] v = 0;
    for (int j = 0; j < SWC; j++) if (sw[j]) v = 5'(j + 1);
    for (int e = EXMIN; e < EXMAX; e++) if (st[e]) v = 5'(e);
    return v;
  endfunction

  function automatic logic [NL-1:0] expMask(logic [SWC-1:0] sw, logic [NL-1:0] st);
    logic [NL-1:0] m = 0;
    for (int j = 0; j < SWC; j++) if (sw[j]) m[SWMIN + j] = 1'b1;
    for (int e = EXMIN; e < EXMAX; e++) if (st[e]) m[e] = 1'b1;
    return m;
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int l = 0; l < NL; l++) mWord[l] = '0;
    mIsr = 0; mId = 0;
  endtask

  // Drive one cycle at the falling edge, update the model, check at the next falling edge.
  task automatic step(bit pv, int pl, int pi, bit cv, int cl, int ci, bit ca,
                      logic [SWC-1:0] sw, int thr, logic [1:0] pc);
    logic [NL-1:0] st;
    logic [4:0] lv;
    bit pOk, cOk;
    postValid = pv; postLevel = 6'(pl); postIndex = 7'(pi);
    clearValid = cv; clearLevel = 6'(cl); clearIndex = 7'(ci);
    clearAll = ca; swRequest = sw; threshold = 5'(thr); pcAlign = pc;
    st = mStatus();
    lv = expLevel(sw, st);
    eTake = (lv != 0) && (lv > 5'(thr)) && (pc == 2'b00);
    if (eTake) begin mIsr = expMask(sw, st); mId = lv; end
    pOk = pv && pl < NL && pi < NS;
    cOk = cv && cl < NL && ci < NS;
    eErr = (pv && !pOk) || (cv && !cOk);
    if (ca) modelReset_words();
    else begin
      if (cOk) mWord[cl][ci] = 1'b0;
      if (pOk) mWord[pl][pi] = 1'b1;
    end
    @(negedge clk);
    chk(statusSummary == mStatus(), "R1 R2 R3 R4 R9 statusSummary", 64'(statusSummary), 64'(mStatus()));
    chk(takeValid == eTake, "R7 takeValid", 64'(takeValid), 64'(eTake));
    chk(isrOut == mIsr, "R6 R8 isrOut", 64'(isrOut), 64'(mIsr));
    chk(intIdOut == mId, "R6 R8 intIdOut", 64'(intIdOut), 64'(mId));
    chk(reqError == eErr, "R9 reqError", 64'(reqError), 64'(eErr));
    chk(intPending == ((mStatus() != 0) && pc == 2'b00), "R5 intPending",
        64'(intPending), 64'((mStatus() != 0) && pc == 2'b00));
  endtask

  task automatic modelReset_words();
    for (int l = 0; l < NL; l++) mWord[l] = '0;
  endtask

  task automatic idle(logic [SWC-1:0] sw, int thr, logic [1:0] pc);
    step(0, 0, 0, 0, 0, 0, 0, sw, thr, pc);
  endtask

  task automatic checkReset(string when);
    chk(statusSummary == 0 && isrOut == 0 && intIdOut == 0 && !takeValid && !reqError,
        {"R10 reset state ", when}, 64'({statusSummary, intIdOut, takeValid, reqError}), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rst = 0;
    checkReset("after power-up");

    // R1: post external level 20 source 3
    step(1, 20, 3, 0, 0, 0, 0, 0, 0, 2'b00);
    idle(0, 0, 2'b00);                         // take of level 20 (R6 R7 R8)
    // R4: post and clear of the same source, post wins
    step(1, 20, 5, 1, 20, 5, 0, 0, 31, 2'b00);
    // R2: clear one of two sources, level stays flagged
    step(0, 0, 0, 1, 20, 3, 0, 0, 31, 2'b00);
    // R2: clear the last source, level drops
    step(0, 0, 0, 1, 20, 5, 0, 0, 31, 2'b00);
    // R6: software only, bit 6 -> level 7
    idle(15'h0041, 3, 2'b00);
    // R7: threshold equal to level, no take
    idle(15'h0040, 7, 2'b00);
    // R7: misaligned PC, no take; R5 low
    step(1, 2, 0, 0, 0, 0, 0, 15'h0040, 0, 2'b10);
    idle(15'h0040, 0, 2'b01);
    // R6: external beats higher software
    step(1, 17, 9, 0, 0, 0, 0, 15'h4000, 0, 2'b00);
    idle(15'h4000, 0, 2'b00);
    // R9: out-of-range level and index ignored
    step(1, 40, 1, 0, 0, 0, 0, 0, 31, 2'b00);
    step(0, 0, 0, 1, 17, 64, 0, 0, 31, 2'b00);
    // R3: clearAll beats a same-cycle post
    step(1, 30, 8, 0, 0, 0, 1, 0, 31, 2'b00);

    for (int n = 0; n < 3000; n++) begin
      int pl, pi, cl, ci;
      pl = ($urandom % 10 == 0) ? 32 + $urandom % 32 : $urandom % 32;
      pi = ($urandom % 10 == 0) ? 64 + $urandom % 64 : $urandom % 4;
      cl = ($urandom % 10 == 0) ? 32 + $urandom % 32 : $urandom % 32;
      ci = ($urandom % 10 == 0) ? 64 + $urandom % 64 : $urandom % 4;
      step($urandom % 2, pl, pi, $urandom % 2, cl, ci, ($urandom % 60 == 0),
           15'($urandom) & 15'($urandom), $urandom % 32, 2'($urandom % 4 == 0 ? 1 : 0));
    end

    // R10: reset with state present
    step(1, 25, 2, 0, 0, 0, 0, 0, 0, 2'b00);
    rst = 1;
    @(negedge clk);
    rst = 0;
    modelReset();
    checkReset("mid-run");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule